// File: doc/BRIEF.md
# Locked Indexed Configuration Port

This block is the configuration front end of a multi-function I/O controller. A host reaches it through two byte-wide ports on a simple bus: an index port at `bus_addr = 0` and a data port at `bus_addr = 1`, with separate write and read strobes. The port stays locked after reset. While it is locked, only the unlock key matcher listens, and it listens only to index-port writes.

The host unlocks the port by writing the four key bytes 0x87, 0x01, 0x55, 0x55 to the index port in that order. Once the port is open, the host writes an index to the index port, then reads or writes the chosen register through the data port. Global registers hold the logical device number, a 16-bit chip identifier, a revision nibble and the exit command. Each logical device has its own bank with an activation bit and a 16-bit I/O base. The logical device number picks which bank appears at the bank indices, and that bank's contents are driven to sibling blocks on the `sel_*` outputs.

The key matcher has five states. LOCKED waits for the first key byte. KEY1, KEY2 and KEY3 record how many key bytes have matched so far. OPEN is the unlocked state. Its transitions are:
- **advance**: the expected key byte moves the matcher one state forward, and KEY3 moves to OPEN.
- **restart**: a wrong byte returns the matcher to LOCKED, or to KEY1 if that byte is 0x87.
- **relock**: the exit command moves OPEN back to LOCKED.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the port is locked (`cfg_open` = 0). While locked, a read of either port returns 0xFF.
- R2: Four consecutive index-port writes of 0x87, 0x01, 0x55, 0x55 set `cfg_open` in the cycle after the fourth write.
- R3: A wrong byte written to the index port during key matching restarts the match. If that byte is 0x87, it counts as the first key byte.
- R4: While the port is locked, data-port writes change no register. Index-port writes only feed the key matcher.
- R5: Writing 0x02 to index 0x02 relocks the port and clears the index to 0x00. Any other value written to index 0x02 has no effect.
- R6: Index 0x07 holds the 8-bit logical device number. It is readable and writable and is driven on `sel_ldn`.
- R7: Index 0x20 reads the high byte of `CHIP_ID` and index 0x21 reads the low byte. Read while locked, the identifier appears as 0xFFFF.
- R8: Index 0x22 reads `REVISION` in bits 3:0 with bits 7:4 at zero. Writes to it are dropped.
- R9: For a logical device below `NUM_DEV`, bank index 0x30 bit 0 is the activation bit (it reads as 0x00 or 0x01). Bank indices 0x60 and 0x61 hold the high and low base bytes. Each device keeps its own values, and the selected device's values appear on `sel_active` and `sel_base`.
- R10: An unimplemented index reads 0x00 and drops writes. This includes the bank indices when the logical device number is `NUM_DEV` or above. In that case `sel_active` and `sel_base` are 0.
- R11: While the port is open, a read of the index port returns the current index.
- R12: `bus_rdata` is 0x00 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | 0 selects the index port, 1 selects the data port |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| cfg_open | output | 1 | High while the port is unlocked |
| sel_ldn | output | 8 | Current logical device number |
| sel_active | output | 1 | Activation bit of the selected device |
| sel_base | output | 16 | I/O base of the selected device |

## Verification
The assertions check, on every cycle, that:
- a locked read returns 0xFF;
- a locked write leaves the exported device state unchanged;
- the exit command always closes the port;
- the port opens only directly after a 0x55 index write;
- the revision's upper nibble reads as zero;
- the selected bank holds still when no write occurs.

Only the bench's scenarios can show the following:
- the exact key ordering, including the restart-on-0x87 case;
- the independence of the device banks under random writes;
- the drop of writes to unimplemented indices and out-of-range devices;
- that a re-unlock after exit finds the index cleared while the bank contents survive.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

    typedef enum logic [2:0] {
        ST_LOCKED,
        ST_KEY1,
        ST_KEY2,
        ST_KEY3,
        ST_OPEN
    } unlock_state_t;

    localparam logic [7:0] KEY_B0 = 8'h87;
    localparam logic [7:0] KEY_B1 = 8'h01;
    localparam logic [7:0] KEY_B2 = 8'h55;
    localparam logic [7:0] KEY_B3 = 8'h55;

    localparam logic [7:0] IDX_EXIT    = 8'h02;
    localparam logic [7:0] EXIT_CMD    = 8'h02;
    localparam logic [7:0] IDX_LDN     = 8'h07;
    localparam logic [7:0] IDX_ID_HI   = 8'h20;
    localparam logic [7:0] IDX_ID_LO   = 8'h21;
    localparam logic [7:0] IDX_REV     = 8'h22;
    localparam logic [7:0] IDX_ACT     = 8'h30;
    localparam logic [7:0] IDX_BASE_HI = 8'h60;
    localparam logic [7:0] IDX_BASE_LO = 8'h61;

endpackage

// File: rtl/cfg_unlock_fsm.sv
module cfg_unlock_fsm
    import cfg_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_byte,
    input  logic       exit_req,
    output logic       cfg_open
);

    unlock_state_t state_q, state_d;

    // A mismatching byte restarts the match; 0x87 is itself the first key byte.
    function automatic unlock_state_t restart_to(input logic [7:0] b);
        return (b == KEY_B0) ? ST_KEY1 : ST_LOCKED;
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_LOCKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (key_wr) state_d = restart_to(key_byte);
            ST_KEY1:   if (key_wr) state_d = (key_byte == KEY_B1) ? ST_KEY2 : restart_to(key_byte);
            ST_KEY2:   if (key_wr) state_d = (key_byte == KEY_B2) ? ST_KEY3 : restart_to(key_byte);
            ST_KEY3:   if (key_wr) state_d = (key_byte == KEY_B3) ? ST_OPEN : restart_to(key_byte);
            ST_OPEN:   if (exit_req) state_d = ST_LOCKED;
            default:   state_d = ST_LOCKED;
        endcase
    end

    always_comb begin
        cfg_open = (state_q == ST_OPEN);
    end

    // R2: the port can only open right after the last key byte was written
    assert_open_after_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(key_wr && key_byte == KEY_B3));

endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
    import cfg_port_pkg::*;
#(
    parameter int NUM_DEV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  ldn,
    input  logic [7:0]  idx,
    input  logic [7:0]  wdata,
    output logic [7:0]  rd_data,
    output logic        sel_active,
    output logic [15:0] sel_base
);

    localparam int SEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

    logic [NUM_DEV-1:0]       act_all;
    logic [NUM_DEV-1:0][15:0] base_all;
    logic                     ldn_valid;
    logic [SEL_W-1:0]         sel_idx;

    assign ldn_valid = (32'(ldn) < NUM_DEV);
    assign sel_idx   = ldn[SEL_W-1:0];

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        logic        act_r;
        logic [15:0] base_r;
        logic        hit;

        assign hit = wr_en && (32'(ldn) == g);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                act_r  <= 1'b0;
                base_r <= 16'h0000;
            end else if (hit) begin
                if (idx == IDX_ACT)     act_r        <= wdata[0];
                if (idx == IDX_BASE_HI) base_r[15:8] <= wdata;
                if (idx == IDX_BASE_LO) base_r[7:0]  <= wdata;
            end
        end

        assign act_all[g]  = act_r;
        assign base_all[g] = base_r;
    end

    always_comb begin
        sel_active = ldn_valid ? act_all[sel_idx]  : 1'b0;
        sel_base   = ldn_valid ? base_all[sel_idx] : 16'h0000;
        unique case (idx)
            IDX_ACT:     rd_data = {7'b0, sel_active};
            IDX_BASE_HI: rd_data = sel_base[15:8];
            IDX_BASE_LO: rd_data = sel_base[7:0];
            default:     rd_data = 8'h00;
        endcase
    end

    // R9: with no write and the same device selected, the exported bank holds
    assert_bank_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (ldn != $past(ldn)) || ($stable(sel_base) && $stable(sel_active)));

endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
    import cfg_port_pkg::*;
#(
    parameter logic [15:0] CHIP_ID  = 16'h8712,
    parameter logic [7:0]  REVISION = 8'h08,
    parameter int          NUM_DEV  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        cfg_open,
    output logic [7:0]  sel_ldn,
    output logic        sel_active,
    output logic [15:0] sel_base
);

    logic [7:0] index_q;
    logic [7:0] ldn_q;
    logic [7:0] bank_rd;
    logic       key_wr, idx_wr, data_wr, exit_req;

    assign key_wr   = bus_wr && !bus_addr && !cfg_open;
    assign idx_wr   = bus_wr && !bus_addr && cfg_open;
    assign data_wr  = bus_wr && bus_addr && cfg_open;
    assign exit_req = data_wr && (index_q == IDX_EXIT) && (bus_wdata == EXIT_CMD);

    cfg_unlock_fsm u_unlock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_byte (bus_wdata),
        .exit_req (exit_req),
        .cfg_open (cfg_open)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            index_q <= 8'h00;
            ldn_q   <= 8'h00;
        end else if (exit_req) begin
            index_q <= 8'h00;
        end else if (idx_wr) begin
            index_q <= bus_wdata;
        end else if (data_wr && index_q == IDX_LDN) begin
            ldn_q <= bus_wdata;
        end
    end

    cfg_dev_bank #(.NUM_DEV(NUM_DEV)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (data_wr),
        .ldn        (ldn_q),
        .idx        (index_q),
        .wdata      (bus_wdata),
        .rd_data    (bank_rd),
        .sel_active (sel_active),
        .sel_base   (sel_base)
    );

    assign sel_ldn = ldn_q;

    always_comb begin
        if (!bus_rd)        bus_rdata = 8'h00;
        else if (!cfg_open) bus_rdata = 8'hFF;
        else if (!bus_addr) bus_rdata = index_q;
        else begin
            unique case (index_q)
                IDX_LDN:   bus_rdata = ldn_q;
                IDX_ID_HI: bus_rdata = CHIP_ID[15:8];
                IDX_ID_LO: bus_rdata = CHIP_ID[7:0];
                IDX_REV:   bus_rdata = {4'h0, REVISION[3:0]};
                default:   bus_rdata = bank_rd;
            endcase
        end
    end

    // R1: locked reads return all ones
    assert_locked_read_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && bus_rd) |-> bus_rdata == 8'hFF);

    // R4: a locked write leaves the exported device state alone
    assert_locked_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && bus_wr) |=> $stable(sel_ldn) && $stable(sel_base) && $stable(sel_active));

    // R5: the exit command always closes the port
    assert_exit_relock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && bus_wr && bus_addr && index_q == IDX_EXIT && bus_wdata == EXIT_CMD) |=> !cfg_open);

    // R8: revision reads carry a zero upper nibble
    assert_rev_nibble_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && bus_rd && bus_addr && index_q == IDX_REV) |-> bus_rdata[7:4] == 4'h0);

endmodule

// File: tb/cfg_index_port_bench.sv
`timescale 1ns/100ps
module cfg_index_port_bench;

    localparam int          NDEV = 4;
    localparam logic [15:0] CID  = 16'h8712;
    localparam logic [7:0]  REV  = 8'h08;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_addr = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        cfg_open;
    logic [7:0]  sel_ldn;
    logic        sel_active;
    logic [15:0] sel_base;

    int n_checks = 0;
    int n_fail   = 0;

    logic        exp_act  [NDEV];
    logic [15:0] exp_base [NDEV];

    always #2.5 clk = ~clk;

    cfg_index_port #(.CHIP_ID(CID), .REVISION(REV), .NUM_DEV(NDEV)) u_cfg_index_port (
        .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata,
        .bus_rdata, .cfg_open, .sel_ldn, .sel_active, .sel_base
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] idx, output logic [7:0] d);
        wr(1'b0, idx);
        rd(1'b1, d);
    endtask

    task automatic unlock();
        wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h55); wr(1'b0, 8'h55);
    endtask

    function automatic logic [7:0] exp_bank(input int dev, input logic [7:0] idx);
        if (dev >= NDEV) return 8'h00;
        case (idx)
            8'h30:   return {7'b0, exp_act[dev]};
            8'h60:   return exp_base[dev][15:8];
            8'h61:   return exp_base[dev][7:0];
            default: return 8'h00;
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d, hi, lo;
        void'($urandom(32'd1234));
        for (int i = 0; i < NDEV; i++) begin exp_act[i] = 1'b0; exp_base[i] = 16'h0; end
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        check("R1 open after reset", 16'(cfg_open), 16'h0);
        rd(1'b1, d); check("R1 locked data read", 16'(d), 16'hFF);
        rd(1'b0, d); check("R1 locked index read", 16'(d), 16'hFF);
        #1 check("R12 idle rdata", 16'(bus_rdata), 16'h00);

        // R7: identifier read while locked appears as all ones
        wr(1'b0, 8'h20); rd(1'b1, hi); wr(1'b0, 8'h21); rd(1'b1, lo);
        check("R7 locked id", {hi, lo}, 16'hFFFF);

        // R4: locked data writes land nowhere
        wr(1'b1, 8'h07); wr(1'b1, 8'h01); wr(1'b1, 8'h30); wr(1'b1, 8'h01);
        check("R4 locked ldn", 16'(sel_ldn), 16'h0);
        check("R4 locked active", 16'(sel_active), 16'h0);

        // R3: wrong third byte aborts
        wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h12); wr(1'b0, 8'h55);
        check("R3 aborted key", 16'(cfg_open), 16'h0);
        // R3: stray 0x87 restarts as first key byte
        wr(1'b0, 8'h87); wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h55);
        check("R2 not open before last byte", 16'(cfg_open), 16'h0);
        wr(1'b0, 8'h55);
        check("R3 R2 open after restart", 16'(cfg_open), 16'h1);

        rd(1'b0, d); check("R4 index after unlock", 16'(d), 16'h00);
        reg_rd(8'h07, d); check("R4 ldn untouched", 16'(d), 16'h00);
        reg_rd(8'h30, d); check("R4 active untouched", 16'(d), 16'h00);

        wr(1'b0, 8'h22); rd(1'b0, d); check("R11 index read", 16'(d), 16'h22);
        rd(1'b1, d); check("R8 revision", 16'(d), {12'h0, REV[3:0]});
        wr(1'b1, 8'hAA); rd(1'b1, d); check("R8 revision write dropped", 16'(d), {12'h0, REV[3:0]});
        reg_rd(8'h20, hi); reg_rd(8'h21, lo); check("R7 chip id", {hi, lo}, CID);

        wr(1'b0, 8'h45); wr(1'b1, 8'h5A); rd(1'b1, d); check("R10 unimplemented", 16'(d), 16'h00);

        wr(1'b0, 8'h07); wr(1'b1, 8'h02); rd(1'b1, d); check("R6 ldn read", 16'(d), 16'h02);
        check("R6 sel_ldn", 16'(sel_ldn), 16'h02);

        // R9: random bank traffic against the model
        for (int it = 0; it < 120; it++) begin
            int dev, kind;
            logic [7:0] v, idx;
            dev  = int'($urandom_range(0, NDEV - 1));
            kind = int'($urandom_range(0, 2));
            v    = 8'($urandom);
            idx  = (kind == 0) ? 8'h30 : (kind == 1) ? 8'h60 : 8'h61;
            wr(1'b0, 8'h07); wr(1'b1, 8'(dev));
            wr(1'b0, idx); wr(1'b1, v);
            if (kind == 0) exp_act[dev] = v[0];
            else if (kind == 1) exp_base[dev][15:8] = v;
            else exp_base[dev][7:0] = v;
            check("R9 sel_base", sel_base, exp_base[dev]);
            check("R9 sel_active", 16'(sel_active), 16'(exp_act[dev]));
            rd(1'b1, d); check("R9 readback", 16'(d), 16'(exp_bank(dev, idx)));
        end
        for (int dv = 0; dv < NDEV; dv++) begin
            wr(1'b0, 8'h07); wr(1'b1, 8'(dv));
            reg_rd(8'h60, hi); reg_rd(8'h61, lo);
            check("R9 bank independence", {hi, lo}, exp_base[dv]);
            reg_rd(8'h30, d); check("R9 activation", 16'(d), 16'(exp_bank(dv, 8'h30)));
        end

        // R10: device number beyond the banks
        wr(1'b0, 8'h07); wr(1'b1, 8'd9);
        wr(1'b0, 8'h60); wr(1'b1, 8'h33);
        rd(1'b1, d); check("R10 out-of-range bank read", 16'(d), 16'h00);
        check("R10 out-of-range sel_base", sel_base, 16'h0);
        check("R10 out-of-range sel_active", 16'(sel_active), 16'h0);
        wr(1'b0, 8'h07); wr(1'b1, 8'd0);
        check("R10 device 0 untouched", sel_base, exp_base[0]);

        // R5: exit
        wr(1'b0, 8'h02); wr(1'b1, 8'h05);
        check("R5 wrong exit value", 16'(cfg_open), 16'h1);
        wr(1'b1, 8'h02);
        check("R5 relocked", 16'(cfg_open), 16'h0);
        rd(1'b1, d); check("R5 R1 relocked read", 16'(d), 16'hFF);
        unlock();
        rd(1'b0, d); check("R5 index cleared", 16'(d), 16'h00);
        check("R5 bank kept", sel_base, exp_base[0]);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule